// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block resolves a 32-bit request address against a bank of eight programmable windows. Each window is configured with an enable flag, a four-bit destination code, an eight-bit attribute, a 16-bit size field, a base and a remap pair. When a window claims an address, the block reports which window claimed it and that window's destination and attribute. It also returns the translated address: the window's remap base with the offset inside the window carried through, plus a separate upper address word. If no window claims the address, a miss flag is raised.

The size field counts in 64 KB units as a run of ones that starts at bit 0. A value of 0 gives 64 KB, 0x00FF gives 16 MB and 0xFFFF covers the whole space. A field whose ones are not contiguous from bit 0 is reported on a per-window error output, and that window never claims an address. Software programs the windows through a plain write port with a combinational read-back. Lookups use a valid/ready stream. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge, and its result appears on the response side from the next cycle. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `resp_valid` is high and `resp_ready` is low, the response holds unchanged and no new request is accepted.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every window register reads zero, `resp_valid` is low, `req_ready` is high and `cfg_err` is all zero.
- R2: A window claims address A when bits 31:16 of A and of the base agree on every bit where the size field is 0. A size of 0 claims exactly 64 KB, and the size 0x00FF claims 16 MB.
- R3: A window whose enable bit (control bit 31) is clear never claims an address.
- R4: When several enabled windows claim the same address, the window with the lowest index is reported on `resp_win`.
- R5: When no window claims the address, `resp_miss` is 1, `resp_win`, `resp_target`, `resp_attr` and `resp_addr_hi` are 0, and `resp_addr` equals the request address.
- R6: On a claim, `resp_addr` = (remap & ~M) | (A & M), where M = {size, 16'hFFFF}. A remap equal to the base leaves the address unchanged.
- R7: On a claim, `resp_addr_hi` equals the claiming window's upper remap word, and `resp_target` and `resp_attr` equal its control fields.
- R8: A size field that is not a run of ones from bit 0 (size & (size+1) != 0) sets that window's `cfg_err` bit, and the window never claims an address.
- R9: `req_ready` = !resp_valid | resp_ready. The result of a request accepted at an edge is visible after that edge. While the response is stalled, all response outputs hold.
- R10: Register map: `cfg_addr[4:2]` selects the window and `cfg_addr[1:0]` selects the register (0 control, 1 base, 2 remap, 3 upper remap). The control register holds enable in bit 31, destination in bits 27:24, attribute in bits 23:16 and size in bits 15:0, with bits 30:28 reading 0. Base and remap read back with bits 15:0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Window index (4:2) and register select (1:0) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| cfg_err | output | 8 | Per-window malformed size flag |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Address to decode |
| resp_valid | output | 1 | Lookup result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_miss | output | 1 | No window claimed the address |
| resp_win | output | 3 | Index of the claiming window |
| resp_target | output | 4 | Destination code of the claiming window |
| resp_attr | output | 8 | Attribute of the claiming window |
| resp_addr | output | 32 | Translated address |
| resp_addr_hi | output | 32 | Upper translated address word |

## Verification
Directed lookups probe the edges of a window. Both the minimum 64 KB size and a 16 MB size are tried on the last byte inside the window and the first byte past it, which separates a correct mask from an off-by-one. Overlapping windows, a disabled window and a malformed size over the same address separate the priority order from the enable and error gating. A remap test that also changes the upper bits separates offset pass-through from base substitution. Random window sets with clustered bases and addresses mix hits, overlaps and misses, and a stalled consumer shows whether a held result is overwritten.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned OFF_W      = 16;
  localparam int unsigned SIZE_W     = ADDR_W - OFF_W;
  localparam int unsigned TGT_W      = 4;
  localparam int unsigned ATTR_W     = 8;
  localparam int unsigned HI_W       = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_WIN    = 8;
  localparam int unsigned WIN_IDX_W  = $clog2(NUM_WIN);
  localparam int unsigned REG_SEL_W  = 2;
  localparam int unsigned CFG_ADDR_W = WIN_IDX_W + REG_SEL_W;

  // control register field positions
  localparam int unsigned CTRL_EN_BIT   = 31;
  localparam int unsigned CTRL_TGT_LSB  = 24;
  localparam int unsigned CTRL_ATTR_LSB = 16;
  localparam int unsigned CTRL_SIZE_LSB = 0;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_CTRL     = 2'd0,
    REG_BASE     = 2'd1,
    REG_REMAP    = 2'd2,
    REG_REMAP_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [SIZE_W-1:0] size;
    logic [SIZE_W-1:0] base;
    logic [SIZE_W-1:0] remap;
    logic [HI_W-1:0]   remap_hi;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  output win_cfg_t              win_cfg [NUM_WIN]
);
  logic [WIN_IDX_W-1:0] sel_win;
  reg_sel_e             sel_reg;

  assign sel_win = cfg_addr[CFG_ADDR_W-1:REG_SEL_W];
  assign sel_reg = reg_sel_e'(cfg_addr[REG_SEL_W-1:0]);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_cfg[g] <= '0;
      end else if (cfg_we && sel_win == WIN_IDX_W'(g)) begin
        unique case (sel_reg)
          REG_CTRL: begin
            win_cfg[g].en   <= cfg_wdata[CTRL_EN_BIT];
            win_cfg[g].tgt  <= cfg_wdata[CTRL_TGT_LSB +: TGT_W];
            win_cfg[g].attr <= cfg_wdata[CTRL_ATTR_LSB +: ATTR_W];
            win_cfg[g].size <= cfg_wdata[CTRL_SIZE_LSB +: SIZE_W];
          end
          REG_BASE:     win_cfg[g].base     <= cfg_wdata[DATA_W-1 -: SIZE_W];
          REG_REMAP:    win_cfg[g].remap    <= cfg_wdata[DATA_W-1 -: SIZE_W];
          REG_REMAP_HI: win_cfg[g].remap_hi <= cfg_wdata[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (sel_reg)
      REG_CTRL: begin
        cfg_rdata[CTRL_EN_BIT]               = win_cfg[sel_win].en;
        cfg_rdata[CTRL_TGT_LSB +: TGT_W]     = win_cfg[sel_win].tgt;
        cfg_rdata[CTRL_ATTR_LSB +: ATTR_W]   = win_cfg[sel_win].attr;
        cfg_rdata[CTRL_SIZE_LSB +: SIZE_W]   = win_cfg[sel_win].size;
      end
      REG_BASE:     cfg_rdata[DATA_W-1 -: SIZE_W] = win_cfg[sel_win].base;
      REG_REMAP:    cfg_rdata[DATA_W-1 -: SIZE_W] = win_cfg[sel_win].remap;
      REG_REMAP_HI: cfg_rdata[HI_W-1:0]           = win_cfg[sel_win].remap_hi;
      default: ;
    endcase
  end
endmodule

// File: rtl/awd_window_match.sv
module awd_window_match
  import awd_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              armed,
  output logic              size_bad,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat
);
  logic [SIZE_W-1:0] hi_bits;
  logic [SIZE_W-1:0] size_inc;

  assign hi_bits  = addr[ADDR_W-1:OFF_W];
  assign size_inc = cfg.size + SIZE_W'(1);
  // a legal size is a run of ones from bit 0: adding one clears every set bit
  assign size_bad = (cfg.size & size_inc) != '0;
  assign armed    = cfg.en && !size_bad;
  assign hit      = armed && (((hi_bits ^ cfg.base) & ~cfg.size) == '0);
  assign xlat     = {(cfg.remap & ~cfg.size) | (hi_bits & cfg.size),
                     addr[OFF_W-1:0]};
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIN-1:0]   hit,
  input  logic [NUM_WIN-1:0]   armed,
  output logic [NUM_WIN-1:0]   grant,
  output logic                 any_hit,
  output logic [WIN_IDX_W-1:0] idx
);
  always_comb begin
    grant   = '0;
    any_hit = 1'b0;
    idx     = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i] && !any_hit) begin
        grant[i] = 1'b1;
        any_hit  = 1'b1;
        idx      = WIN_IDX_W'(i);
      end
    end
  end

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  grant_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~armed) == '0);
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  output logic [NUM_WIN-1:0]    cfg_err,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic                  resp_miss,
  output logic [WIN_IDX_W-1:0]  resp_win,
  output logic [TGT_W-1:0]      resp_target,
  output logic [ATTR_W-1:0]     resp_attr,
  output logic [ADDR_W-1:0]     resp_addr,
  output logic [HI_W-1:0]       resp_addr_hi
);
  win_cfg_t              win_cfg [NUM_WIN];
  logic [NUM_WIN-1:0]    hit, armed, grant;
  logic [ADDR_W-1:0]     xlat [NUM_WIN];
  logic                  any_hit;
  logic [WIN_IDX_W-1:0]  win_idx;
  logic [ADDR_W-1:0]     sel_xlat;
  logic [HI_W-1:0]       sel_hi;
  logic [TGT_W-1:0]      sel_tgt;
  logic [ATTR_W-1:0]     sel_attr;
  logic                  accept;

  awd_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win_cfg   (win_cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    awd_window_match u_match (
      .cfg      (win_cfg[g]),
      .addr     (req_addr),
      .armed    (armed[g]),
      .size_bad (cfg_err[g]),
      .hit      (hit[g]),
      .xlat     (xlat[g])
    );
  end

  awd_prio_sel u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .armed   (armed),
    .grant   (grant),
    .any_hit (any_hit),
    .idx     (win_idx)
  );

  // one-hot grant makes an OR across windows a mux
  always_comb begin
    sel_xlat = '0;
    sel_hi   = '0;
    sel_tgt  = '0;
    sel_attr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) begin
        sel_xlat = sel_xlat | xlat[i];
        sel_hi   = sel_hi   | win_cfg[i].remap_hi;
        sel_tgt  = sel_tgt  | win_cfg[i].tgt;
        sel_attr = sel_attr | win_cfg[i].attr;
      end
    end
  end

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_miss    <= 1'b0;
      resp_win     <= '0;
      resp_target  <= '0;
      resp_attr    <= '0;
      resp_addr    <= '0;
      resp_addr_hi <= '0;
    end else if (accept) begin
      resp_valid   <= 1'b1;
      resp_miss    <= !any_hit;
      resp_win     <= win_idx;
      resp_target  <= sel_tgt;
      resp_attr    <= sel_attr;
      resp_addr    <= any_hit ? sel_xlat : req_addr;
      resp_addr_hi <= sel_hi;
    end else if (resp_ready) begin
      resp_valid   <= 1'b0;
    end
  end

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable({resp_miss, resp_win,
      resp_target, resp_attr, resp_addr, resp_addr_hi})));

  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> req_ready);

  // R5
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_miss) |-> (resp_win == '0 && resp_target == '0 &&
      resp_attr == '0 && resp_addr_hi == '0));
endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_miss;
  logic [2:0]  resp_win;
  logic [3:0]  resp_target;
  logic [7:0]  resp_attr;
  logic [31:0] resp_addr;
  logic [31:0] resp_addr_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model of the programmed windows
  bit         m_en    [8];
  logic [3:0] m_tgt   [8];
  logic [7:0] m_attr  [8];
  logic [15:0] m_size [8];
  logic [15:0] m_base [8];
  logic [15:0] m_remap[8];
  logic [31:0] m_hi   [8];

  always #2.5 clk = ~clk;

  addr_window_decoder i_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_miss(resp_miss),
    .resp_win(resp_win), .resp_target(resp_target), .resp_attr(resp_attr),
    .resp_addr(resp_addr), .resp_addr_hi(resp_addr_hi)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit contiguous(input logic [15:0] s);
    logic [15:0] inc;
    inc = s + 16'd1;
    return (s & inc) == 16'd0;
  endfunction

  // {miss, win, target, attr, addr, addr_hi}
  function automatic logic [127:0] expect_resp(input logic [31:0] a);
    logic [15:0] hb;
    hb = a[31:16];
    for (int i = 0; i < 8; i++) begin
      if (m_en[i] && contiguous(m_size[i]) &&
          ((hb & ~m_size[i]) == (m_base[i] & ~m_size[i])))
        return {1'b0, 3'(i), m_tgt[i], m_attr[i],
                (m_remap[i] & ~m_size[i]) | (hb & m_size[i]), a[15:0], m_hi[i]};
    end
    return {1'b1, 3'd0, 4'd0, 8'd0, a, 32'd0};
  endfunction

  function automatic logic [127:0] actual_resp();
    return {resp_miss, resp_win, resp_target, resp_attr, resp_addr, resp_addr_hi};
  endfunction

  task automatic wr(input logic [2:0] w, input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {w, r}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_win(input int w, input bit en, input logic [3:0] tgt,
                         input logic [7:0] attr, input logic [15:0] size,
                         input logic [15:0] base, input logic [15:0] remap,
                         input logic [31:0] hi);
    wr(3'(w), 2'd0, {en, 3'b000, tgt, attr, size});
    wr(3'(w), 2'd1, {base, 16'h0});
    wr(3'(w), 2'd2, {remap, 16'h0});
    wr(3'(w), 2'd3, hi);
    m_en[w] = en; m_tgt[w] = tgt; m_attr[w] = attr; m_size[w] = size;
    m_base[w] = base; m_remap[w] = remap; m_hi[w] = hi;
  endtask

  task automatic clear_all();
    for (int w = 0; w < 8; w++) set_win(w, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic lookup(input string req, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {resp_valid, actual_resp()}, {1'b1, expect_resp(a)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    logic [127:0] held;
    seed_dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_tgt[i] = 0; m_attr[i] = 0; m_size[i] = 0;
      m_base[i] = 0; m_remap[i] = 0; m_hi[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {resp_valid, req_ready, cfg_err}, {1'b0, 1'b1, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      cfg_addr = 5'(k); #1;
      chk("R1 register reads zero", cfg_rdata, 0);
    end

    // R10: reserved and unused bits read zero
    wr(3'd1, 2'd0, 32'hFFFF_FFFF);
    cfg_addr = {3'd1, 2'd0}; #1;
    chk("R10 control readback", cfg_rdata, 32'h8FFF_FFFF);
    wr(3'd1, 2'd1, 32'h1234_5678);
    cfg_addr = {3'd1, 2'd1}; #1;
    chk("R10 base readback", cfg_rdata, 32'h1234_0000);
    wr(3'd1, 2'd3, 32'hCAFE_0001);
    cfg_addr = {3'd1, 2'd3}; #1;
    chk("R10 upper remap readback", cfg_rdata, 32'hCAFE_0001);
    clear_all();

    // R2: 64 KB window at size 0
    set_win(0, 1, 4'h3, 8'h11, 16'h0000, 16'h1000, 16'h1000, 0);
    lookup("R2 64KB first byte", 32'h1000_0000);
    lookup("R2 64KB last byte", 32'h1000_FFFF);
    lookup("R2 64KB past end miss R5", 32'h1001_0000);
    lookup("R2 64KB below start miss R5", 32'h0FFF_FFFF);
    // R2: 16 MB window
    set_win(1, 1, 4'h5, 8'h22, 16'h00FF, 16'h2000, 16'h2000, 0);
    lookup("R2 16MB last byte", 32'h20FF_FFFF);
    lookup("R2 16MB past end miss", 32'h2100_0000);

    // R3: disabled window
    set_win(2, 0, 4'h7, 8'h33, 16'h00FF, 16'h3000, 16'h3000, 0);
    lookup("R3 disabled window misses", 32'h3012_3456);

    // R8: malformed size
    set_win(3, 1, 4'h8, 8'h44, 16'h0005, 16'h4000, 16'h4000, 0);
    chk("R8 cfg_err flag", cfg_err, 8'b0000_1000);
    lookup("R8 malformed window misses", 32'h4000_0010);
    set_win(3, 1, 4'h8, 8'h44, 16'h0007, 16'h4000, 16'h4000, 0);
    chk("R8 cfg_err cleared", cfg_err, 8'h00);
    lookup("R8 repaired window hits", 32'h4005_0010);

    // R4: overlap priority
    clear_all();
    set_win(5, 1, 4'hA, 8'h55, 16'h0FFF, 16'h5000, 16'h9000, 32'h0000_0001);
    set_win(2, 1, 4'hB, 8'h66, 16'h00FF, 16'h5000, 16'h7000, 32'h0000_0002);
    lookup("R4 lower index wins", 32'h5012_3456);
    lookup("R4 only higher window covers", 32'h5812_3456);
    set_win(2, 0, 4'hB, 8'h66, 16'h00FF, 16'h5000, 16'h7000, 32'h0000_0002);
    lookup("R4 R3 disabled lower falls through", 32'h5012_3456);

    // R6/R7: remap translation and identity
    clear_all();
    set_win(6, 1, 4'h2, 8'hE1, 16'h000F, 16'hC030, 16'hA5A5, 32'h0000_00F1);
    lookup("R6 R7 remapped address", 32'hC03B_BEEF);
    set_win(7, 1, 4'h1, 8'h01, 16'h00FF, 16'hD100, 16'hD100, 0);
    lookup("R6 identity when remap equals base", 32'hD1AB_CDEF);

    // R9: stall holds response, blocks request
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'hC03F_0000;
    @(negedge clk);
    req_addr = 32'hD100_0042;
    held = expect_resp(32'hC03F_0000);
    chk("R9 ready low when stalled", {resp_valid, req_ready}, {1'b1, 1'b0});
    repeat (3) @(negedge clk);
    chk("R9 stalled response holds", actual_resp(), held);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next request after drain", {resp_valid, actual_resp()},
        {1'b1, expect_resp(32'hD100_0042)});
    @(negedge clk);
    chk("R9 drained response", {resp_valid, req_ready}, {1'b0, 1'b1});

    // random rounds: R2 R4 R6 R7 R8
    for (int round = 0; round < 6; round++) begin
      for (int w = 0; w < 8; w++) begin
        logic [15:0] sz;
        int k;
        k = $urandom_range(0, 9);
        sz = (16'd1 << k) - 16'd1;
        if ($urandom_range(0, 9) == 0) sz = 16'h0005;
        set_win(w, ($urandom_range(0, 3) != 0), 4'($urandom), 8'($urandom), sz,
                {6'b100000, 2'($urandom), 8'($urandom)}, 16'($urandom), $urandom);
      end
      for (int n = 0; n < 60; n++) begin
        logic [31:0] a;
        a = {6'b100000, 2'($urandom), 24'($urandom)};
        lookup("R2 R4 R6 random lookup", a);
      end
      chk("R8 random cfg_err", cfg_err,
          {~contiguous(m_size[7]), ~contiguous(m_size[6]), ~contiguous(m_size[5]),
           ~contiguous(m_size[4]), ~contiguous(m_size[3]), ~contiguous(m_size[2]),
           ~contiguous(m_size[1]), ~contiguous(m_size[0])});
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule